// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two entries from a page table held in memory. The first read fetches a page directory entry. The second read fetches a page table entry. Each entry is one 32-bit word. A requester presents the linear address, a write flag and a user-mode flag. The directory root and the paging-enable bit are sampled in the same cycle. When the walk ends, the block returns one result. That result is either the physical address with the effective write and user permissions of the page, or a page fault with a three-bit cause code.

The walker handles one translation at a time. The walk is a named state machine:

- `W_IDLE` accepts a request.
- `W_DIR_REQ` drives the directory read until the memory port takes it, then goes to `W_DIR_WAIT`.
- `W_DIR_WAIT` waits for the directory word. It goes to `W_TBL_REQ` when the entry is present, and to `W_DONE` when it is not.
- `W_TBL_REQ` and `W_TBL_WAIT` do the same for the table entry, then go to `W_DONE`.
- `W_DONE` shows the result for one cycle and returns to `W_IDLE`.
- When paging is off, `W_IDLE` goes straight to `W_DONE`.

Translations are not cached, accessed and dirty bits are not written back, and there are no large pages.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: When `paging_en` is 0 at acceptance, the following hold:
  - no memory read is issued;
  - `rsp_valid` rises in the cycle after acceptance;
  - `rsp_paddr` equals the linear address;
  - both permission outputs are 1 and `rsp_fault` is 0.
- R3: The linear address is split as follows:
  - bits 31..22 are the directory index;
  - bits 21..12 are the table index;
  - bits 11..0 are the page offset.
  The first read address is {root[31:12], directory index, 2'b00}.
- R4: The second read address is {directory entry[31:12], table index, 2'b00}. It is issued only after the directory word has returned.
- R5: On success, `rsp_paddr` is {table entry[31:12], linear[11:0]}.
- R6: Bit 0 of an entry is the present bit.
  - If the directory entry has bit 0 clear, the walk faults after exactly one read.
  - If the table entry has bit 0 clear, the walk faults after two reads.
- R7: On success, the permission outputs combine both levels:
  - `rsp_write_ok` is the AND of bit 1 of both entries;
  - `rsp_user_ok` is the AND of bit 2 of both entries.
- R8: A user-mode access faults when the combined user bit is 0. A user-mode write also faults when the combined write bit is 0. A supervisor access never takes a protection fault.
- R9: `rsp_cause` encodes the fault as follows:
  - bit 0 is 1 for a protection fault and 0 for a not-present fault;
  - bit 1 copies the write flag;
  - bit 2 copies the user flag.
  `rsp_cause` is 0 when there is no fault.
- R10: A request is accepted only when `req_ready` is 1, which happens only in `W_IDLE`. Once `mem_req_valid` rises, it stays high and `mem_req_addr` stays unchanged until `mem_req_ready` is 1.
- R11: `rsp_valid` is high for a single cycle. On a fault, `rsp_paddr`, `rsp_write_ok` and `rsp_user_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle; request taken when both high |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| cr3_base | input | 32 | Page directory root (bits 31..12 used) |
| paging_en | input | 1 | Translation enabled |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_write_ok | output | 1 | Combined write permission |
| rsp_user_ok | output | 1 | Combined user permission |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 3 | Fault cause {user, write, protection} |

## Verification
The translation is tried with the following patterns:

- **Paging disabled.** This separates the identity path from the walk.
- **Fully permissive entries under two different roots.** This shows that the root and both indices reach the read addresses and the result.
- **A missing directory entry versus a missing table entry.** The number of reads and the cause bits tell these apart.
- **A supervisor-only table entry, accessed in user mode and in supervisor mode.** This separates the user check from the present check.
- **A read-only directory entry, accessed as a user write, a user read and a supervisor write.** This shows that the write permission is the AND of both levels and that it only restricts user accesses.

A memory model with varying ready and latency confirms that request hold and read ordering do not depend on timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_REQ,
        W_DIR_WAIT,
        W_TBL_REQ,
        W_TBL_WAIT,
        W_DONE
    } walk_state_t;

    localparam int ENT_PRESENT = 0;
    localparam int ENT_WRITE   = 1;
    localparam int ENT_USER    = 2;

    typedef struct packed {
        logic user;
        logic write;
        logic prot;
    } fault_cause_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int AW     = 32,
    parameter int OFFS_W = 12
) (
    input  logic [AW-1:0] root_base,
    input  logic [AW-1:0] dir_entry,
    input  logic [AW-1:0] laddr,
    output logic [AW-1:0] dir_ent_addr,
    output logic [AW-1:0] tbl_ent_addr
);
    localparam int IDX_W   = OFFS_W - 2;
    localparam int DIR_LSB = OFFS_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx      = laddr[DIR_LSB +: IDX_W];
        tbl_idx      = laddr[OFFS_W +: IDX_W];
        dir_ent_addr = {root_base[AW-1:OFFS_W], dir_idx, 2'b00};
        tbl_ent_addr = {dir_entry[AW-1:OFFS_W], tbl_idx, 2'b00};
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] dir_entry,
    input  logic [AW-1:0] tbl_entry,
    input  logic          acc_write,
    input  logic          acc_user,
    output logic          eff_write,
    output logic          eff_user,
    output logic          prot_fault
);
    always_comb begin
        eff_write  = dir_entry[ENT_WRITE] & tbl_entry[ENT_WRITE];
        eff_user   = dir_entry[ENT_USER]  & tbl_entry[ENT_USER];
        prot_fault = acc_user & (~eff_user | (acc_write & ~eff_write));
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int AW     = 32,
    parameter int OFFS_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic          req_write,
    input  logic          req_user,
    input  logic [AW-1:0] cr3_base,
    input  logic          paging_en,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_write_ok,
    output logic          rsp_user_ok,
    output logic          rsp_fault,
    output logic [2:0]    rsp_cause
);
    walk_state_t state_q, state_d;

    logic [AW-1:0] laddr_q, root_q, pde_q, paddr_q;
    logic          wr_q, usr_q;
    logic          wok_q, uok_q, fault_q;
    fault_cause_t  cause_q;

    logic [AW-1:0] dir_ent_addr, tbl_ent_addr;
    logic          eff_write, eff_user, prot_fault;

    ptw_addr_gen #(.AW(AW), .OFFS_W(OFFS_W)) u_addr (
        .root_base    (root_q),
        .dir_entry    (pde_q),
        .laddr        (laddr_q),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr)
    );

    ptw_perm_check #(.AW(AW)) u_perm (
        .dir_entry  (pde_q),
        .tbl_entry  (mem_rsp_data),
        .acc_write  (wr_q),
        .acc_user   (usr_q),
        .eff_write  (eff_write),
        .eff_user   (eff_user),
        .prot_fault (prot_fault)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:     if (req_valid) state_d = paging_en ? W_DIR_REQ : W_DONE;
            W_DIR_REQ:  if (mem_req_ready) state_d = W_DIR_WAIT;
            W_DIR_WAIT: if (mem_rsp_valid)
                            state_d = mem_rsp_data[ENT_PRESENT] ? W_TBL_REQ : W_DONE;
            W_TBL_REQ:  if (mem_req_ready) state_d = W_TBL_WAIT;
            W_TBL_WAIT: if (mem_rsp_valid) state_d = W_DONE;
            W_DONE:     state_d = W_IDLE;
            default:    state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            root_q  <= '0;
            pde_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            paddr_q <= '0;
            wok_q   <= 1'b0;
            uok_q   <= 1'b0;
            fault_q <= 1'b0;
            cause_q <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: if (req_valid) begin
                    laddr_q <= req_laddr;
                    root_q  <= cr3_base;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    fault_q <= 1'b0;
                    cause_q <= '0;
                    paddr_q <= paging_en ? '0 : req_laddr;
                    wok_q   <= ~paging_en;
                    uok_q   <= ~paging_en;
                end
                W_DIR_WAIT: if (mem_rsp_valid) begin
                    pde_q <= mem_rsp_data;
                    if (!mem_rsp_data[ENT_PRESENT]) begin
                        fault_q <= 1'b1;
                        cause_q <= '{user: usr_q, write: wr_q, prot: 1'b0};
                    end
                end
                W_TBL_WAIT: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[ENT_PRESENT]) begin
                        fault_q <= 1'b1;
                        cause_q <= '{user: usr_q, write: wr_q, prot: 1'b0};
                    end else if (prot_fault) begin
                        fault_q <= 1'b1;
                        cause_q <= '{user: usr_q, write: wr_q, prot: 1'b1};
                    end else begin
                        paddr_q <= {mem_rsp_data[AW-1:OFFS_W], laddr_q[OFFS_W-1:0]};
                        wok_q   <= eff_write;
                        uok_q   <= eff_user;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == W_IDLE);
        mem_req_valid = (state_q == W_DIR_REQ) || (state_q == W_TBL_REQ);
        mem_req_addr  = (state_q == W_TBL_REQ) ? tbl_ent_addr : dir_ent_addr;
        rsp_valid     = (state_q == W_DONE);
        rsp_paddr     = paddr_q;
        rsp_write_ok  = wok_q;
        rsp_user_ok   = uok_q;
        rsp_fault     = fault_q;
        rsp_cause     = cause_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_write_ok && !rsp_user_ok); // R11
    AST_USER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && usr_q |-> rsp_user_ok); // R8
    AST_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && usr_q && wr_q |-> rsp_write_ok); // R8
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R3
    AST_TBL_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) && state_q == W_TBL_REQ |-> $past(mem_rsp_valid)); // R4
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] cr3_base = '0;
    logic        paging_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_write_ok, rsp_user_ok, rsp_fault;
    logic [2:0]  rsp_cause;

    always #2 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user), .cr3_base(cr3_base),
        .paging_en(paging_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_write_ok(rsp_write_ok),
        .rsp_user_ok(rsp_user_ok), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model
    logic [31:0] tbmem [logic [31:0]];
    logic [31:0] readlog [$];
    int          cyc = 0;
    int          pend = 0;
    int          nrd = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (tbmem.exists(a)) return tbmem[a];
        return 32'h0;
    endfunction

    assign mem_req_ready = (cyc % 3) != 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (pend == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rd(pend_addr);
        end
        if (pend > 0) pend <= pend - 1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            readlog.push_back(mem_req_addr);
            pend_addr <= mem_req_addr;
            pend      <= 1 + (nrd % 3);
            nrd       <= nrd + 1;
        end
    end

    // scoreboard
    typedef struct {
        logic [31:0] pa;
        bit          wok, uok, flt;
        logic [2:0]  cause;
        int          n;
        logic [31:0] a0, a1;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    function automatic exp_t model(input logic [31:0] la, input bit wr, input bit usr,
                                   input logic [31:0] root, input bit pg, input string tag);
        exp_t e;
        logic [31:0] pde, pte;
        bit w, u;
        e.tag = tag; e.pa = 0; e.wok = 0; e.uok = 0; e.flt = 0; e.cause = 0;
        e.n = 0; e.a0 = 0; e.a1 = 0;
        if (!pg) begin
            e.pa = la; e.wok = 1; e.uok = 1;
            return e;
        end
        e.a0 = {root[31:12], la[31:22], 2'b00};
        pde = rd(e.a0); e.n = 1;
        if (!pde[0]) begin e.flt = 1; e.cause = {usr, wr, 1'b0}; return e; end
        e.a1 = {pde[31:12], la[21:12], 2'b00};
        pte = rd(e.a1); e.n = 2;
        if (!pte[0]) begin e.flt = 1; e.cause = {usr, wr, 1'b0}; return e; end
        w = pde[1] & pte[1];
        u = pde[2] & pte[2];
        if (usr && (!u || (wr && !w))) begin
            e.flt = 1; e.cause = {usr, wr, 1'b1}; return e;
        end
        e.pa = {pte[31:12], la[11:0]}; e.wok = w; e.uok = u;
        return e;
    endfunction

    bit prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp && rsp_valid) chk(0, "R11 pulse", 32'd1, 32'd0);
            prev_rsp <= rsp_valid;
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(0, "R11 unexpected response", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_paddr == e.pa, {e.tag, " paddr R5"}, rsp_paddr, e.pa);
                    chk(rsp_fault == e.flt, {e.tag, " fault R6"}, 32'(rsp_fault), 32'(e.flt));
                    chk(rsp_cause == e.cause, {e.tag, " cause R9"}, 32'(rsp_cause), 32'(e.cause));
                    chk(rsp_write_ok == e.wok, {e.tag, " write_ok R7"},
                        32'(rsp_write_ok), 32'(e.wok));
                    chk(rsp_user_ok == e.uok, {e.tag, " user_ok R7"},
                        32'(rsp_user_ok), 32'(e.uok));
                    chk(readlog.size() == e.n, {e.tag, " read count R6"},
                        32'(readlog.size()), 32'(e.n));
                    if (e.n >= 1 && readlog.size() >= 1)
                        chk(readlog[0] == e.a0, {e.tag, " dir addr R3"}, readlog[0], e.a0);
                    if (e.n >= 2 && readlog.size() >= 2)
                        chk(readlog[1] == e.a1, {e.tag, " table addr R4"}, readlog[1], e.a1);
                end
                readlog.delete();
            end
        end
    end

    task automatic walk(input logic [31:0] la, input bit wr, input bit usr,
                        input logic [31:0] root, input bit pg, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(model(la, wr, usr, root, pg, tag));
        req_laddr = la; req_write = wr; req_user = usr; cr3_base = root; paging_en = pg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " busy R10"}, 32'(req_ready), 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // page tables
        tbmem[32'h0010_0004] = 32'h0020_0007;
        tbmem[32'h0020_0008] = 32'hABCD_E007;
        tbmem[32'h0010_0008] = 32'h0030_0007;
        tbmem[32'h0030_0000] = 32'h1111_1003;
        tbmem[32'h0010_000C] = 32'h0040_0005;
        tbmem[32'h0040_0000] = 32'h2222_2007;
        tbmem[32'h0050_0000] = 32'h0020_0007;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        walk(32'h1234_5678, 1, 1, 32'h0010_0000, 0, "R2 paging off");
        walk(32'h0040_2003, 0, 1, 32'h0010_0000, 1, "R5 example walk");
        walk(32'h0000_2FFF, 1, 0, 32'h0050_0000, 1, "R3 other root");
        walk(32'h0140_0000, 0, 1, 32'h0010_0000, 1, "R6 dir absent");
        walk(32'h0040_3000, 1, 0, 32'h0010_0000, 1, "R6 table absent");
        walk(32'h0080_0ABC, 0, 1, 32'h0010_0000, 1, "R8 user on supervisor page");
        walk(32'h0080_0ABC, 0, 0, 32'h0010_0000, 1, "R8 supervisor read");
        walk(32'h00C0_0010, 1, 1, 32'h0010_0000, 1, "R8 user write read-only dir");
        walk(32'h00C0_0010, 0, 1, 32'h0010_0000, 1, "R7 user read read-only dir");
        walk(32'h00C0_0010, 1, 0, 32'h0010_0000, 1, "R8 supervisor write read-only");
        walk(32'hFFFF_FFFF, 0, 0, 32'h0010_0000, 0, "R2 paging off high");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule